// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit forms a load-address result from three terms: an unsigned 12-bit displacement, an index register value and a base register value. A register specifier of zero names no register. In that case the matching term counts as zero, whatever value the register file port presents.

The sum is formed at full 32-bit width. It is then cut down to the active addressing width. In 24-bit mode the top eight bits of the result are cleared. In 31-bit mode only the most significant bit is cleared. Any carry out of the kept bits is dropped, and no flag is raised.

The result is captured on the rising clock edge when the input valid is high. It is delivered one cycle later on a register write port, together with a write enable and the destination specifier. When the destination register is also the base or the index, the unit acts as an incrementer. A negative starting value then always comes out with its top bit clear.

Top module: `eag_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `wr_en` = 0, `wr_data` = 0 and `wr_sel` = 0.
- R2: When `in_valid` is high at a rising edge, the following cycle shows `wr_en` = 1. `wr_data` then carries the masked sum of displacement + index value + base value, and `wr_sel` equals `dst_sel`.
- R3: A `base_sel` value of 0 makes the base term zero, regardless of `base_val`.
- R4: An `index_sel` value of 0 makes the index term zero, regardless of `index_val`.
- R5: The displacement is zero-extended, so `disp` = 12'hFFF adds 4095 and is never treated as a negative number.
- R6: With `amode31` = 0 (24-bit mode), `wr_data[31:24]` is 0 and `wr_data[23:0]` holds the low 24 bits of the sum.
- R7: With `amode31` = 1 (31-bit mode), `wr_data[31]` is 0 and `wr_data[30:0]` holds the low 31 bits of the sum. This holds even when a base or index value with bit 31 set is incremented.
- R8: A carry out of the kept bits is discarded without any indication, so the result wraps modulo 2^24 or 2^31.
- R9: When `in_valid` is low at a rising edge, the next cycle shows `wr_en` = 0, and `wr_data` and `wr_sel` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are present this cycle |
| amode31 | input | 1 | 0 selects 24-bit addressing, 1 selects 31-bit addressing |
| base_sel | input | 4 | Base register specifier; 0 means no base |
| index_sel | input | 4 | Index register specifier; 0 means no index |
| dst_sel | input | 4 | Destination register specifier, forwarded to the write port |
| disp | input | 12 | Unsigned displacement |
| base_val | input | 32 | Value read for the base specifier |
| index_val | input | 32 | Value read for the index specifier |
| wr_en | output | 1 | Write enable of the register write port |
| wr_sel | output | 4 | Destination register of the write |
| wr_data | output | 32 | Load-address result |

## Verification
Operand suppression and mode truncation can act on the same operation. For example, a suppressed base can be combined with an index of all ones and a non-zero displacement, so the dropped carry depends on which terms survive. The bench provokes this with directed cases and with a long random run. In that run the specifiers are often zero while the register values are still driven with large, non-zero values. Every cycle, the result is judged against a behavioural model that adds only the terms whose specifier is non-zero and then truncates to the selected width.

// File: rtl/eag_pkg.sv
package eag_pkg;

    typedef enum logic {
        AMODE_24 = 1'b0,
        AMODE_31 = 1'b1
    } amode_e;

endpackage

// File: rtl/eag_operand_gate.sv
module eag_operand_gate #(
    parameter int WIDTH  = 32,
    parameter int SPEC_W = 4
) (
    input  logic [SPEC_W-1:0] spec,
    input  logic [WIDTH-1:0]  reg_val,
    output logic [WIDTH-1:0]  term
);
    localparam logic [SPEC_W-1:0] NO_REG = '0;

    always_comb begin
        if (spec == NO_REG) begin
            term = '0;
        end else begin
            term = reg_val;
        end
    end
endmodule

// File: rtl/eag_sum3.sv
module eag_sum3 #(
    parameter int WIDTH  = 32,
    parameter int DISP_W = 12
) (
    input  logic [DISP_W-1:0] disp,
    input  logic [WIDTH-1:0]  term_x,
    input  logic [WIDTH-1:0]  term_b,
    output logic [WIDTH-1:0]  sum
);
    localparam int PAD_W = WIDTH - DISP_W;

    logic [WIDTH-1:0] disp_ext;
    logic [WIDTH-1:0] partial;

    always_comb begin
        disp_ext = {{PAD_W{1'b0}}, disp};
        partial  = disp_ext + term_x;
        sum      = partial + term_b;
    end
endmodule

// File: rtl/eag_mode_mask.sv
module eag_mode_mask
    import eag_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int NARROW_W = 24,
    parameter int WIDE_W   = 31
) (
    input  amode_e           mode,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] masked
);
    localparam logic [WIDTH-1:0] ONES        = '1;
    localparam logic [WIDTH-1:0] NARROW_KEEP = ONES >> (WIDTH - NARROW_W);
    localparam logic [WIDTH-1:0] WIDE_KEEP   = ONES >> (WIDTH - WIDE_W);

    always_comb begin
        unique case (mode)
            AMODE_24: masked = raw & NARROW_KEEP;
            default:  masked = raw & WIDE_KEEP;
        endcase
    end
endmodule

// File: rtl/eag_unit.sv
module eag_unit
    import eag_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DISP_W   = 12,
    parameter int SPEC_W   = 4,
    parameter int NARROW_W = 24,
    parameter int WIDE_W   = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              amode31,
    input  logic [SPEC_W-1:0] base_sel,
    input  logic [SPEC_W-1:0] index_sel,
    input  logic [SPEC_W-1:0] dst_sel,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    output logic              wr_en,
    output logic [SPEC_W-1:0] wr_sel,
    output logic [ADDR_W-1:0] wr_data
);
    localparam int NUM_OPS = 2;
    localparam int PAD_W   = ADDR_W - DISP_W;

    typedef struct packed {
        logic              en;
        logic [SPEC_W-1:0] sel;
        logic [ADDR_W-1:0] data;
    } wport_t;

    wport_t state_d, state_q;

    logic [SPEC_W-1:0] op_spec [NUM_OPS];
    logic [ADDR_W-1:0] op_val  [NUM_OPS];
    logic [ADDR_W-1:0] op_term [NUM_OPS];
    logic [ADDR_W-1:0] raw_sum;
    logic [ADDR_W-1:0] masked_sum;
    amode_e            mode;

    always_comb begin
        op_spec[0] = index_sel;
        op_val[0]  = index_val;
        op_spec[1] = base_sel;
        op_val[1]  = base_val;
        mode       = amode31 ? AMODE_31 : AMODE_24;
    end

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_gate
        eag_operand_gate #(
            .WIDTH  (ADDR_W),
            .SPEC_W (SPEC_W)
        ) u_gate (
            .spec    (op_spec[g]),
            .reg_val (op_val[g]),
            .term    (op_term[g])
        );
    end

    eag_sum3 #(
        .WIDTH  (ADDR_W),
        .DISP_W (DISP_W)
    ) u_sum (
        .disp   (disp),
        .term_x (op_term[0]),
        .term_b (op_term[1]),
        .sum    (raw_sum)
    );

    eag_mode_mask #(
        .WIDTH    (ADDR_W),
        .NARROW_W (NARROW_W),
        .WIDE_W   (WIDE_W)
    ) u_mask (
        .mode   (mode),
        .raw    (raw_sum),
        .masked (masked_sum)
    );

    always_comb begin
        state_d    = state_q;
        state_d.en = 1'b0;
        if (rst) begin
            state_d = '0;
        end else if (in_valid) begin
            state_d.en   = 1'b1;
            state_d.sel  = dst_sel;
            state_d.data = masked_sum;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign wr_en   = state_q.en;
    assign wr_sel  = state_q.sel;
    assign wr_data = state_q.data;

    always_comb begin
        if (!rst && base_sel == '0 && index_sel == '0) begin
            AST_BARE_DISP: assert (raw_sum == {{PAD_W{1'b0}}, disp}); // R3
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!wr_en && wr_data == '0)); // R1

    AST_VALID_WRITES: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (wr_en && wr_sel == $past(dst_sel))); // R2

    AST_TOP_BYTE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !amode31) |=> (wr_data[ADDR_W-1:NARROW_W] == '0)); // R6

    AST_MSB_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && amode31) |=> !wr_data[ADDR_W-1]); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!wr_en && $stable(wr_data) && $stable(wr_sel))); // R9

endmodule

// File: tb/tb_eag_unit.sv
module tb_eag_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        amode31;
    logic [3:0]  base_sel, index_sel, dst_sel;
    logic [11:0] disp;
    logic [31:0] base_val, index_val;
    logic        wr_en;
    logic [3:0]  wr_sel;
    logic [31:0] wr_data;

    int compared   = 0;
    int mismatched = 0;
    bit finished   = 0;

    // behavioural model state
    bit          nxt_en, exp_en;
    logic [3:0]  nxt_sel, exp_sel;
    logic [31:0] nxt_data, exp_data;
    string       nxt_tag, exp_tag;

    always #4 clk = ~clk;

    eag_unit dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .amode31   (amode31),
        .base_sel  (base_sel),
        .index_sel (index_sel),
        .dst_sel   (dst_sel),
        .disp      (disp),
        .base_val  (base_val),
        .index_val (index_val),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data)
    );

    function automatic logic [31:0] model_ea(input bit m31, input logic [3:0] bs,
        input logic [31:0] bv, input logic [3:0] xs, input logic [31:0] xv,
        input logic [11:0] d);
        longint s;
        s = longint'(d);
        if (xs != 0) s += longint'(xv);
        if (bs != 0) s += longint'(bv);
        if (m31) s = s % 64'h8000_0000;
        else     s = s % 64'h100_0000;
        return s[31:0];
    endfunction

    // compare, then drive one cycle, then predict the next
    task automatic step(input string tag, input bit r, input bit v, input bit m31,
        input logic [3:0] bs, input logic [31:0] bv, input logic [3:0] xs,
        input logic [31:0] xv, input logic [11:0] d, input logic [3:0] ds);
        @(negedge clk);
        exp_en = nxt_en; exp_sel = nxt_sel; exp_data = nxt_data; exp_tag = nxt_tag;
        compared++;
        if (wr_en !== exp_en || wr_sel !== exp_sel || wr_data !== exp_data) begin
            mismatched++;
            $display("FAIL %s: got en=%0b sel=%0d data=%08h, expected en=%0b sel=%0d data=%08h",
                     exp_tag, wr_en, wr_sel, wr_data, exp_en, exp_sel, exp_data);
        end
        rst = r; in_valid = v; amode31 = m31; base_sel = bs; base_val = bv;
        index_sel = xs; index_val = xv; disp = d; dst_sel = ds;
        nxt_tag = tag;
        if (r) begin
            nxt_en = 0; nxt_sel = 0; nxt_data = 0;
        end else if (v) begin
            nxt_en = 1; nxt_sel = ds; nxt_data = model_ea(m31, bs, bv, xs, xv, d);
        end else begin
            nxt_en = 0; nxt_sel = exp_sel; nxt_data = exp_data;
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        rst = 1; in_valid = 0; amode31 = 0; base_sel = 0; index_sel = 0; dst_sel = 0;
        disp = 0; base_val = 0; index_val = 0;
        nxt_en = 0; nxt_sel = 0; nxt_data = 0; nxt_tag = "R1";
        @(negedge clk);
        step("R1", 1, 1, 1, 4'd3, 32'hFFFF_FFFF, 4'd2, 32'h1234, 12'h5, 4'd7);
        step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R2 plain sum in both modes
        step("R2", 0, 1, 1, 4'd6, 32'h0000_4800, 4'd5, 32'h0000_0040, 12'h002, 4'd4);
        step("R2", 0, 1, 0, 4'd1, 32'h0012_3456, 4'd2, 32'h0000_1000, 12'h111, 4'd9);
        // R3 base suppressed although base_val is non-zero
        step("R3", 0, 1, 1, 4'd0, 32'h7FFF_0000, 4'd6, 32'h0000_0040, 12'h800, 4'd7);
        // R4 index suppressed
        step("R4", 0, 1, 1, 4'd6, 32'h0000_0100, 4'd0, 32'h1234_5678, 12'h00A, 4'd6);
        // R3 and R4 together: bare displacement
        step("R3", 0, 1, 0, 4'd0, 32'hDEAD_BEEF, 4'd0, 32'hCAFE_F00D, 12'h00C, 4'd6);
        // R5 top displacement is +4095
        step("R5", 0, 1, 1, 4'd0, 0, 4'd0, 0, 12'hFFF, 4'd2);
        step("R5", 0, 1, 1, 4'd1, 32'h0000_1000, 4'd0, 0, 12'hFFF, 4'd2);
        // R6 24-bit masking of large operands
        step("R6", 0, 1, 0, 4'd4, 32'hAB12_3456, 4'd5, 32'h0100_0001, 12'h001, 4'd1);
        // R7 31-bit increment of a negative value
        step("R7", 0, 1, 1, 4'd6, 32'h8000_000A, 4'd0, 0, 12'h00A, 4'd6);
        step("R7", 0, 1, 0, 4'd0, 0, 4'd6, 32'hFF00_000A, 12'h00A, 4'd6);
        // R8 carries out of kept bits dropped
        step("R8", 0, 1, 1, 4'd1, 32'hFFFF_FFFF, 4'd2, 32'hFFFF_FFFF, 12'hFFF, 4'd3);
        step("R8", 0, 1, 0, 4'd1, 32'h00FF_FFFF, 4'd0, 32'h0, 12'h001, 4'd3);
        // R9 idle cycles hold data and drop enable
        step("R9", 0, 0, 1, 4'd1, 32'h1111_1111, 4'd2, 32'h2222_2222, 12'h333, 4'd8);
        step("R9", 0, 0, 0, 4'd3, 32'h5555_5555, 4'd4, 32'h6666_6666, 12'h777, 4'd9);
        step("R2", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R1 reset in the middle of traffic
        step("R1", 1, 1, 1, 4'd1, 32'h10, 4'd1, 32'h10, 12'h10, 4'd5);
        step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // mixed random traffic: suppression together with truncation
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r0, r1, r2;
            r0 = $urandom; r1 = $urandom; r2 = $urandom;
            step("R8", 0, r0[0] | r0[1], r0[2], (r0[3]) ? 4'd0 : r0[7:4], r1,
                 (r0[8]) ? 4'd0 : r0[12:9], r2, r0[24:13], r0[28:25]);
        end
        step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule